// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of bytes from a transmit FIFO into a bit-serial HDLC line signal. Each frame opens with a flag octet (8'h7E). The data bytes follow, least significant bit first, and then a 16-bit frame check sequence and a closing flag. Zero-bit insertion is applied to the data and check-sequence bits so that a flag can never appear inside a frame. The FIFO presents one entry at a time, and each entry carries two marks. The end-of-frame mark makes the last byte close the frame. The abort mark makes the framer send an abort sequence in place of that byte.

Between frames a 2-bit line-mode input selects what fills the line. The choices are all ones, back-to-back flags, or a repeating go-ahead pattern. Idle and flag fill give way to a new frame as soon as data is waiting. Go-ahead never does: it holds until the mode input changes. The framer advances by one bit on each clock where the bit enable is high, which lets a slower line rate share the system clock.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While rstN is low, txBit is 1 and fifoPop is 0.
- R2: A frame is sent as the flag 8'h7E (bit order 0,1,1,1,1,1,1,0), then each FIFO byte LSB first in FIFO order, then the check sequence, then a closing 8'h7E. A byte whose end-of-frame mark (fifoLast) is set is the last data byte of its frame.
- R3: The check sequence is the CRC with generator x^16+x^12+x^5+1. It is preset to 16'hFFFF, computed over the data bits only, and sent as the ones' complement, low-order bit first. Run over the data and check-sequence bits, a receiver's CRC therefore ends at 16'hF0B8.
- R4: After five consecutive 1s among data or check-sequence bits, a 0 is inserted. This includes the last check-sequence bits. Flags, abort sequences and fill patterns are never stuffed, so inside a frame no run of more than six 1s appears.
- R5: An entry popped with its abort mark (fifoAbort) set is replaced on the line by eight 1s. That frame then gets no check sequence and no closing flag, and the line returns to the fill selected by lineMode.
- R6: If the FIFO is empty when the next data byte is due inside a frame, the framer sends an abort sequence of eight 1s and returns to interframe fill. The next frame is sent normally.
- R7: With lineMode 2'b00 or 2'b11 and no frame in progress, txBit is held at 1. Ones are sent in groups of eight, so an opening flag starts a whole multiple of 8 bits after the fill began.
- R8: With lineMode 2'b01 and no frame in progress, flags 8'h7E are sent back to back. A new frame's opening flag follows the flag in progress.
- R9: With lineMode 2'b10 and no frame in progress, the 9-bit pattern 0,1,1,1,1,1,1,1,0 is repeated. No FIFO entry is popped, even when data is waiting, until lineMode changes.
- R10: txBit changes only on clock edges where bitEn is high, and advances one line bit per such edge.
- R11: fifoPop pulses for one cycle per consumed entry, and only when fifoValid and bitEn are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Line-bit enable; one serial bit per enabled edge |
| lineMode | input | 2 | Interframe fill: 00/11 ones, 01 flags, 10 go-ahead |
| fifoValid | input | 1 | FIFO head entry is present |
| fifoData | input | 8 | FIFO head data byte |
| fifoLast | input | 1 | Head entry ends the frame |
| fifoAbort | input | 1 | Head entry is to be replaced by an abort |
| fifoPop | output | 1 | Head entry consumed on this edge |
| txBit | output | 1 | Serial line output |

## Verification
A corrupted ones counter or a skipped stuffing cycle shows up at txBit within a few bits. The receiver sees a false flag, or a run of six 1s followed by a 1, or it loses its byte alignment, so the frame fails to decode or fails the residue check at its closing flag. A CRC register that is not preset, or that is clocked on the wrong bits, stays hidden until the check sequence goes out. At that point every frame fails the 16'hF0B8 residue. A control state stuck in the frame body shows as a missing closing flag or a pop at the wrong time, and a fill item of the wrong length shows as a broken period in the interframe pattern within one or two patterns.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W = 16;
  localparam int SH_W = FCS_W;
  localparam int GA_W = 9;
  localparam int STUFF_RUN = 5;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [GA_W-1:0] GA_PATTERN = 9'h0FE;
  localparam logic [FCS_W-1:0] CRC_PRESET = 16'hFFFF;
  localparam logic [FCS_W-1:0] CRC_POLY_REV = 16'h8408;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_FLAGS = 2'b01,
    MODE_GOAHEAD = 2'b10,
    MODE_IDLE_ALT = 2'b11
  } lineMode_e;

  typedef enum logic [2:0] {
    ITEM_ONES,
    ITEM_FLAG,
    ITEM_GOAHEAD,
    ITEM_DATA,
    ITEM_ABORT,
    ITEM_CRC
  } item_e;

  typedef struct packed {
    logic load;
    item_e item;
    logic crcInit;
  } txStrobe_t;
endpackage

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  txStrobe_t         strobe,
  input  logic [BYTE_W-1:0] dataByte,
  output logic              needItem,
  output logic              txBit
);
  localparam int LEN_W = $clog2(SH_W + 1);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);

  logic [SH_W-1:0] shReg, loadVal, srcBits;
  logic [LEN_W-1:0] bitsLeft, loadLen, baseLen;
  logic [ONES_W-1:0] onesCnt, nextOnes;
  logic [FCS_W-1:0] crc;
  logic stuffOn, crcOn, loadStuff, loadCrc, srcStuff, srcCrc;
  logic stuffPend, doLoad, doShift, emitBit, txBitQ;

  function automatic logic [FCS_W-1:0] crcStep(input logic [FCS_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_REV : '0);
  endfunction

  assign stuffPend = stuffOn && (onesCnt == ONES_W'(STUFF_RUN));
  assign needItem = bitEn && !stuffPend && (bitsLeft == '0);
  assign doLoad = strobe.load && needItem;
  assign doShift = bitEn && !stuffPend && (bitsLeft != '0);

  always_comb begin
    loadVal = SH_W'({BYTE_W{1'b1}});
    loadLen = LEN_W'(BYTE_W);
    loadStuff = 1'b0;
    loadCrc = 1'b0;
    unique case (strobe.item)
      ITEM_FLAG: loadVal = SH_W'(FLAG_BYTE);
      ITEM_GOAHEAD: begin
        loadVal = SH_W'(GA_PATTERN);
        loadLen = LEN_W'(GA_W);
      end
      ITEM_DATA: begin
        loadVal = SH_W'(dataByte);
        loadStuff = 1'b1;
        loadCrc = 1'b1;
      end
      ITEM_CRC: begin
        loadVal = ~crc;
        loadLen = LEN_W'(FCS_W);
        loadStuff = 1'b1;
      end
      default: loadVal = SH_W'({BYTE_W{1'b1}});
    endcase
  end

  assign srcBits = doLoad ? loadVal : shReg;
  assign baseLen = doLoad ? loadLen : bitsLeft;
  assign srcStuff = doLoad ? loadStuff : stuffOn;
  assign srcCrc = doLoad ? loadCrc : crcOn;
  assign emitBit = srcBits[0];
  assign nextOnes = srcStuff ? (emitBit ? onesCnt + 1'b1 : '0) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      bitsLeft <= '0;
      stuffOn <= 1'b0;
      crcOn <= 1'b0;
      onesCnt <= '0;
      crc <= CRC_PRESET;
      txBitQ <= 1'b1;
    end else if (bitEn && stuffPend) begin
      txBitQ <= 1'b0;
      onesCnt <= '0;
    end else if (doShift || doLoad) begin
      txBitQ <= emitBit;
      shReg <= srcBits >> 1;
      bitsLeft <= baseLen - 1'b1;
      stuffOn <= srcStuff;
      crcOn <= srcCrc;
      onesCnt <= nextOnes;
      if (doLoad && strobe.crcInit) crc <= CRC_PRESET;
      else if (srcCrc) crc <= crcStep(crc, emitBit);
    end
  end

  assign txBit = txBitQ;
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      needItem,
  input  lineMode_e mode,
  input  logic      fifoValid,
  input  logic      fifoLast,
  input  logic      fifoAbort,
  output txStrobe_t strobe,
  output logic      fifoPop,
  output logic      inFrame
);
  typedef enum logic [1:0] {ST_GAP, ST_BODY, ST_FCS, ST_CLOSE} ctlState_e;
  ctlState_e state, nextState;

  always_comb begin
    strobe = '0;
    strobe.load = needItem;
    strobe.item = ITEM_ONES;
    nextState = state;
    fifoPop = 1'b0;
    unique case (state)
      ST_GAP: begin
        if (mode == MODE_GOAHEAD) begin
          strobe.item = ITEM_GOAHEAD;
        end else if (fifoValid) begin
          strobe.item = ITEM_FLAG;
          strobe.crcInit = 1'b1;
          nextState = ST_BODY;
        end else if (mode == MODE_FLAGS) begin
          strobe.item = ITEM_FLAG;
        end
      end
      ST_BODY: begin
        if (fifoValid) begin
          fifoPop = needItem;
          if (fifoAbort) begin
            strobe.item = ITEM_ABORT;
            nextState = ST_GAP;
          end else begin
            strobe.item = ITEM_DATA;
            nextState = fifoLast ? ST_FCS : ST_BODY;
          end
        end else begin
          strobe.item = ITEM_ABORT;
          nextState = ST_GAP;
        end
      end
      ST_FCS: begin
        strobe.item = ITEM_CRC;
        nextState = ST_CLOSE;
      end
      ST_CLOSE: begin
        strobe.item = ITEM_FLAG;
        nextState = ST_GAP;
      end
      default: nextState = ST_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_GAP;
    else if (needItem) state <= nextState;
  end

  assign inFrame = (state != ST_GAP);
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [1:0]        lineMode,
  input  logic              fifoValid,
  input  logic [BYTE_W-1:0] fifoData,
  input  logic              fifoLast,
  input  logic              fifoAbort,
  output logic              fifoPop,
  output logic              txBit
);
  txStrobe_t strobe;
  logic needItem;
  logic inFrame;

  hdlc_tx_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .needItem(needItem),
    .mode(lineMode_e'(lineMode)),
    .fifoValid(fifoValid),
    .fifoLast(fifoLast),
    .fifoAbort(fifoAbort),
    .strobe(strobe),
    .fifoPop(fifoPop),
    .inFrame(inFrame)
  );

  hdlc_tx_dp u_dp (
    .clk(clk),
    .rstN(rstN),
    .bitEn(bitEn),
    .strobe(strobe),
    .dataByte(fifoData),
    .needItem(needItem),
    .txBit(txBit)
  );
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic [1:0] lineMode,
  input logic       fifoValid,
  input logic       fifoPop,
  input logic       txBit,
  input logic       inFrame
);
  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN) fifoPop |-> fifoValid); // R11
  AST_POP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN) fifoPop |-> bitEn); // R11
  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN) !bitEn |=> $stable(txBit)); // R10
  AST_GOAHEAD_NO_POP: assert property (@(posedge clk) disable iff (!rstN) (lineMode == 2'b10 && !inFrame) |-> !fifoPop); // R9
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .bitEn(bitEn),
  .lineMode(lineMode),
  .fifoValid(fifoValid),
  .fifoPop(fifoPop),
  .txBit(txBit),
  .inFrame(inFrame)
);

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int REC_MAX = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic [1:0] lineMode = 2'b00;
  logic fifoValid = 1'b0;
  logic [7:0] fifoData = 8'h00;
  logic fifoLast = 1'b0;
  logic fifoAbort = 1'b0;
  logic fifoPop;
  logic txBit;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hdlc_tx_framer uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .lineMode(lineMode),
    .fifoValid(fifoValid), .fifoData(fifoData), .fifoLast(fifoLast),
    .fifoAbort(fifoAbort), .fifoPop(fifoPop), .txBit(txBit)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] qData [0:63];
  logic qLast [0:63];
  logic qAbort [0:63];
  int qCount, qIdx;
  logic rec [0:REC_MAX-1];
  int recLen, cyc, enPeriod, popCount, holdErr, popEnErr;
  logic popSeen, enSeen, prevTx;
  int nFrames, nAborts;
  logic [7:0] fBytes [0:3][0:15];
  int fLens [0:3];
  logic fOk [0:3];

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic driveFifo();
    fifoValid = (qIdx < qCount);
    fifoData = fifoValid ? qData[qIdx] : 8'h00;
    fifoLast = fifoValid ? qLast[qIdx] : 1'b0;
    fifoAbort = fifoValid ? qAbort[qIdx] : 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    if (popSeen) begin
      qIdx++;
      popCount++;
      if (!enSeen) popEnErr++;
    end
    if (enSeen) begin
      if (recLen < REC_MAX) begin
        rec[recLen] = txBit;
        recLen++;
      end
    end else if (txBit !== prevTx) begin
      holdErr++;
    end
    prevTx = txBit;
    cyc++;
    bitEn = ((cyc % enPeriod) == 0);
    driveFifo();
    #1;
    popSeen = fifoPop;
    enSeen = bitEn;
  endtask

  task automatic push(input logic [7:0] d, input logic last, input logic abrt);
    qData[qCount] = d;
    qLast[qCount] = last;
    qAbort[qCount] = abrt;
    qCount++;
  endtask

  task automatic doReset(input logic [1:0] mode, input int period);
    @(negedge clk);
    rstN = 1'b0;
    lineMode = mode;
    enPeriod = period;
    qCount = 0;
    qIdx = 0;
    bitEn = 1'b0;
    driveFifo();
    repeat (3) @(negedge clk);
    checkEq("R1 txBit during reset", int'(txBit), 1);
    checkEq("R1 fifoPop during reset", int'(fifoPop), 0);
    rstN = 1'b1;
    cyc = 0;
    bitEn = 1'b1;
    recLen = 0;
    popCount = 0;
    holdErr = 0;
    popEnErr = 0;
    prevTx = txBit;
    #1;
    popSeen = fifoPop;
    enSeen = bitEn;
  endtask

  function automatic int maxRun(input int fromIdx, input int toIdx);
    int run = 0;
    int best = 0;
    for (int i = fromIdx; i < toIdx; i++) begin
      run = rec[i] ? run + 1 : 0;
      if (run > best) best = run;
    end
    return best;
  endfunction

  function automatic int firstZero();
    for (int i = 0; i < recLen; i++) if (rec[i] == 1'b0) return i;
    return -1;
  endfunction

  task automatic decode();
    logic bb [0:REC_MAX-1];
    int ones = 0;
    int bl = 0;
    bit sawFlag = 0;
    nFrames = 0;
    nAborts = 0;
    for (int i = 0; i < recLen; i++) begin
      if (rec[i]) begin
        ones++;
        bb[bl] = 1'b1;
        bl++;
        if (ones >= 7) begin
          if (ones == 7 && sawFlag && bl > 7) nAborts++;
          sawFlag = 0;
          bl = 0;
        end
      end else begin
        if (ones == 5) begin
          // stuffed zero, dropped
        end else if (ones == 6) begin
          int fl = bl - 7;
          if (sawFlag && fl >= 24 && (fl % 8) == 0) begin
            logic [15:0] c = 16'hFFFF;
            int nb = (fl - 16) / 8;
            for (int k = 0; k < fl; k++) begin
              logic fb = c[0] ^ bb[k];
              c = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
            end
            if (nFrames < 4 && nb <= 16) begin
              fLens[nFrames] = nb;
              fOk[nFrames] = (c == 16'hF0B8);
              for (int b = 0; b < nb; b++)
                for (int j = 0; j < 8; j++) fBytes[nFrames][b][j] = bb[b * 8 + j];
            end
            nFrames++;
          end
          sawFlag = 1;
          bl = 0;
        end else begin
          bb[bl] = 1'b0;
          bl++;
        end
        ones = 0;
      end
    end
  endtask

  task automatic testIdleFrame();
    int fz;
    int onesTail = 0;
    doReset(2'b00, 1);
    repeat (37) tick();
    checkEq("R7 idle line before data", maxRun(0, recLen), recLen);
    push(8'h12, 0, 0);
    push(8'hA5, 0, 0);
    push(8'h3C, 1, 0);
    repeat (200) tick();
    fz = firstZero();
    checkEq("R7 opening flag on 8-bit boundary", fz % 8, 0);
    decode();
    checkEq("R2 one frame decoded", nFrames, 1);
    checkEq("R2 frame length", fLens[0], 3);
    checkEq("R2 byte0", int'(fBytes[0][0]), 'h12);
    checkEq("R2 byte1", int'(fBytes[0][1]), 'hA5);
    checkEq("R2 byte2", int'(fBytes[0][2]), 'h3C);
    checkEq("R3 check sequence residue", int'(fOk[0]), 1);
    checkEq("R11 one pop per byte", popCount, 3);
    for (int i = recLen - 16; i < recLen; i++) onesTail += int'(rec[i]);
    checkEq("R7 ones after frame", onesTail, 16);
  endtask

  task automatic testStuffing();
    doReset(2'b01, 1);
    push(8'hFF, 0, 0);
    push(8'hFF, 0, 0);
    push(8'h7E, 0, 0);
    push(8'hF8, 0, 0);
    push(8'h1F, 1, 0);
    repeat (250) tick();
    decode();
    checkEq("R4 stuffed frame decoded", nFrames, 1);
    checkEq("R4 byte0 all ones", int'(fBytes[0][0]), 'hFF);
    checkEq("R4 byte2 flag value as data", int'(fBytes[0][2]), 'h7E);
    checkEq("R4 byte4", int'(fBytes[0][4]), 'h1F);
    checkEq("R3 residue with stuffing", int'(fOk[0]), 1);
    checkEq("R4 longest ones run", maxRun(0, recLen), 6);
  endtask

  task automatic testFlagFill();
    int errs = 0;
    int v = 0;
    doReset(2'b01, 1);
    repeat (80) tick();
    for (int j = 0; j < 8; j++) v[j] = rec[j];
    checkEq("R8 first fill octet", v, 'h7E);
    for (int i = 0; i + 8 < recLen; i++) if (rec[i] !== rec[i + 8]) errs++;
    checkEq("R8 fill period 8", errs, 0);
  endtask

  task automatic testAbort();
    doReset(2'b01, 1);
    push(8'h11, 0, 0);
    push(8'h22, 0, 1);
    repeat (120) tick();
    decode();
    checkEq("R5 abort detected", nAborts, 1);
    checkEq("R5 no frame after abort", nFrames, 0);
    checkEq("R5 abort is eight ones", maxRun(0, recLen), 8);
    checkEq("R5 both entries popped", popCount, 2);
  endtask

  task automatic testUnderrun();
    doReset(2'b01, 1);
    push(8'h55, 0, 0);
    repeat (80) tick();
    push(8'h42, 1, 0);
    repeat (120) tick();
    decode();
    checkEq("R6 underrun aborts", nAborts, 1);
    checkEq("R6 next frame sent", nFrames, 1);
    checkEq("R6 next frame byte", int'(fBytes[0][0]), 'h42);
    checkEq("R6 next frame residue", int'(fOk[0]), 1);
  endtask

  task automatic testGoAhead();
    int errs = 0;
    int v = 0;
    int gaLen;
    doReset(2'b10, 1);
    push(8'h5A, 1, 0);
    repeat (120) tick();
    gaLen = recLen;
    checkEq("R9 no pop in go-ahead", popCount, 0);
    for (int j = 0; j < 9; j++) v[j] = rec[j];
    checkEq("R9 pattern bits", v, 'h0FE);
    for (int i = 0; i + 9 < gaLen; i++) if (rec[i] !== rec[i + 9]) errs++;
    checkEq("R9 pattern period 9", errs, 0);
    lineMode = 2'b01;
    repeat (150) tick();
    decode();
    checkEq("R9 frame after mode change", nFrames, 1);
    checkEq("R9 frame byte", int'(fBytes[0][0]), 'h5A);
    checkEq("R9 pop after mode change", popCount, 1);
  endtask

  task automatic testBitEnable();
    doReset(2'b00, 3);
    push(8'hC3, 0, 0);
    push(8'h99, 1, 0);
    repeat (400) tick();
    decode();
    checkEq("R10 frame at reduced rate", nFrames, 1);
    checkEq("R10 byte1", int'(fBytes[0][1]), 'h99);
    checkEq("R10 residue", int'(fOk[0]), 1);
    checkEq("R10 hold when disabled", holdErr, 0);
    checkEq("R11 pops only when enabled", popEnErr, 0);
    checkEq("R10 bit count", recLen, 134);
  endtask

  task automatic testAltIdle();
    doReset(2'b11, 1);
    repeat (64) tick();
    checkEq("R7 mode 11 holds ones", maxRun(0, recLen), recLen);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testIdleFrame();
    testStuffing();
    testFlagFill();
    testAbort();
    testUnderrun();
    testGoAhead();
    testBitEnable();
    testAltIdle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule